// File: doc/BRIEF.md
# Eight-Input Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines and raises one interrupt output toward a processor. Software reaches it through a small register bus: a chip select, one address bit that chooses the command port (0) or the data port (1), read and write strobes, and an 8-bit data bus. A further select input, `sel_trig`, steers data-port accesses to the per-line trigger register. After reset the block waits for a configuration sequence. A command-port write with bit 4 set begins that sequence. The following data-port writes supply the vector base, then the cascade word, then the mode word. After that the block runs. In the running state it takes end-of-interrupt and readback-select commands on the command port, and mask accesses on the data port.

Each line is either edge-triggered or level-sensitive, as its trigger bit selects. Priority is fixed, and line 0 is the highest. A request is offered only when its line is unmasked and it outranks every level now in service. When the processor pulses `inta` for one cycle, the block returns an 8-bit vector one cycle later with `vec_vld`. In the same step it moves the chosen request into service, unless automatic end-of-interrupt is enabled. An acknowledge that finds no request to offer returns the level-7 vector and leaves the in-service register unchanged. Software can detect this case by reading the in-service register.

The configuration sequence is a five-state machine:
- ST_WAIT_INIT is the state after reset.
- ST_GET_BASE, ST_GET_CASC and ST_GET_MODE take the second, third and fourth words.
- ST_RUN is normal operation.

A command-port write with bit 4 set moves the machine from any state to ST_GET_BASE. From ST_GET_BASE a data write goes to ST_GET_CASC when the cascade word is expected. It goes to ST_GET_MODE when the cascade word is skipped and a mode word is expected. Otherwise it goes to ST_RUN. From ST_GET_CASC a data write goes to ST_GET_MODE or to ST_RUN. From ST_GET_MODE a data write goes to ST_RUN.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask register is 0xFF, the in-service register is 0, the request register is selected for command-port reads, the state is ST_WAIT_INIT, and `intr` is low.
- R2: A command-port write with bit 4 set starts configuration. It clears the in-service register, selects the request register for readback and clears automatic end-of-interrupt. Data writes that follow without `sel_trig` are taken in order: vector base, then cascade word, then mode word. Bit 1 of the first word set skips the cascade word and leaves the stored cascade word unchanged. Bit 0 of the first word clear skips the mode word. The next data write after the sequence goes to the mask register.
- R3: In ST_RUN or ST_WAIT_INIT, a data-port access without `sel_trig` reads or writes the mask register. A masked line is never offered, and 0xFF masks every line. A masked line's request bit is still recorded.
- R4: A data-port access with `sel_trig` high reads or writes the trigger register, which resets to 0. Bit n of that register equal to 0 makes line n edge-triggered, and 1 makes it level-sensitive.
- R5: An edge-triggered line sets its request bit on a rising edge of its pin only. The bit stays set, even after the pin falls, until that line is acknowledged.
- R6: A level-sensitive line's request bit follows its pin: it is set while the pin is high and clear while the pin is low.
- R7: Priority is fixed, and line 0 is the highest. `intr` is high only in ST_RUN, and only when the highest-priority unmasked request has a lower index than every set in-service bit.
- R8: On an `inta` pulse with a request offered at level n, `vec_out` equals {base[7:3], n} with `vec_vld` high in the next cycle. Request bit n is cleared, and in-service bit n is set.
- R9: Command byte 0x60+n clears only in-service bit n. Command byte 0x20 clears the highest-priority set in-service bit.
- R10: Command byte 0x0A selects the request register and 0x0B selects the in-service register for command-port reads. The selection holds until it is changed.
- R11: With bit 1 of the mode word set (automatic end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R12: An `inta` pulse with no request offered returns {base[7:3], 7} and leaves the in-service register unchanged.
- R13: The cascade word (a cascade bitmask or a 3-bit slave identifier) is stored and shown on `casc_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| a0 | input | 1 | Port select: 0 selects the command port, 1 selects the data port |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, one cycle per write |
| sel_trig | input | 1 | Steers data-port accesses to the trigger register |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, combinational while cs and rd are high, otherwise 0 |
| irq_in | input | 8 | Interrupt request pins |
| inta | input | 1 | Interrupt acknowledge, one-cycle pulse |
| intr | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned for the latest acknowledge |
| vec_vld | output | 1 | High in the cycle after an acknowledge |
| casc_word | output | 8 | Stored cascade word |

## Verification
The main function is tried with several request patterns:
- A single edge request, which shows the basic offer, the vector and the move into service.
- A lower-priority request arriving while a higher level is in service. It stays blocked until the higher level ends, which shows that the in-service register gates priority.
- A request arriving above a level already in service. It preempts at once, which shows that fixed priority is applied.
- A short pulse on an edge line, compared with the same pulse on a level line. The edge bit stays latched and the level bit falls back, which separates the two trigger modes.
- A line that is masked and then unmasked, which separates the mask from the recording of requests.

Acknowledges are also tried in three other settings. An acknowledge with nothing pending separates a spurious acknowledge from a real one. Acknowledges under automatic end-of-interrupt, and under a shortened configuration sequence, show the mode word and the skip flags at work.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_WAIT_INIT,
        ST_GET_BASE,
        ST_GET_CASC,
        ST_GET_MODE,
        ST_RUN
    } cfg_state_t;
endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
    import pic8_pkg::*;
#(
    parameter int NL = 8,
    parameter int LW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          a0,
    input  logic          wr,
    input  logic          sel_trig,
    input  logic [NL-1:0] din,
    output logic          run,
    output logic [NL-1:0] vbase,
    output logic [NL-1:0] casc,
    output logic          aeoi,
    output logic [NL-1:0] mask,
    output logic [NL-1:0] trig,
    output logic          rd_isr,
    output logic          eoi_spec,
    output logic          eoi_any,
    output logic [LW-1:0] eoi_lvl,
    output logic          init_clr
);
    cfg_state_t state, nxt;
    logic skip_casc, want_mode;
    logic wr_cmd, wr_dat, wr_word, run_cmd;

    assign wr_cmd   = cs && wr && !a0;
    assign wr_dat   = cs && wr && a0;
    assign wr_word  = wr_dat && !sel_trig;
    assign init_clr = wr_cmd && din[4];
    assign run_cmd  = wr_cmd && !din[4] && (state == ST_RUN);
    assign eoi_spec = run_cmd && !din[3] && (din[7:5] == 3'b011);
    assign eoi_any  = run_cmd && !din[3] && (din[7:5] == 3'b001);
    assign eoi_lvl  = din[LW-1:0];
    assign run      = (state == ST_RUN);

    always_comb begin
        nxt = state;
        if (init_clr) begin
            nxt = ST_GET_BASE;
        end else begin
            unique case (state)
                ST_WAIT_INIT: nxt = ST_WAIT_INIT;
                ST_GET_BASE: if (wr_word)
                    nxt = !skip_casc ? ST_GET_CASC : (want_mode ? ST_GET_MODE : ST_RUN);
                ST_GET_CASC: if (wr_word) nxt = want_mode ? ST_GET_MODE : ST_RUN;
                ST_GET_MODE: if (wr_word) nxt = ST_RUN;
                ST_RUN:       nxt = ST_RUN;
                default:      nxt = ST_WAIT_INIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_INIT;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbase     <= '0;
            casc      <= '0;
            aeoi      <= 1'b0;
            mask      <= '1;
            trig      <= '0;
            rd_isr    <= 1'b0;
            skip_casc <= 1'b0;
            want_mode <= 1'b0;
        end else begin
            if (init_clr) begin
                skip_casc <= din[1];
                want_mode <= din[0];
                aeoi      <= 1'b0;
                rd_isr    <= 1'b0;
            end
            if (wr_dat && sel_trig) trig <= din;
            if (wr_word) begin
                unique case (state)
                    ST_GET_BASE:  vbase <= din;
                    ST_GET_CASC:  casc  <= din;
                    ST_GET_MODE:  aeoi  <= din[1];
                    ST_RUN,
                    ST_WAIT_INIT: mask  <= din;
                    default:      mask  <= mask;
                endcase
            end
            if (run_cmd && din[3] && din[1]) rd_isr <= din[0];
        end
    end

    // R2: the word after the first word is the vector base
    a_r2_base_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GET_BASE && wr_word) |=> (vbase == $past(din)));
    // R2: a new first word always returns the sequence to the base word
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> (state == ST_GET_BASE && !rd_isr && !aeoi));
    // R3: a running data write without trigger select lands in the mask
    a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && wr_word) |=> (mask == $past(din)));
endmodule

// File: rtl/pic8_req.sv
module pic8_req #(
    parameter int NL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] pin,
    input  logic [NL-1:0] trig,
    input  logic [NL-1:0] clr,
    output logic [NL-1:0] irr
);
    logic [NL-1:0] pin_d;

    always_ff @(posedge clk) begin
        if (!rst_n) pin_d <= '0;
        else        pin_d <= pin;
    end

    for (genvar i = 0; i < NL; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                irr[i] <= 1'b0;
            else if (trig[i])
                irr[i] <= pin[i];
            else
                irr[i] <= (irr[i] && !clr[i]) || (pin[i] && !pin_d[i]);
        end

        // R5: an edge-mode request holds until it is acknowledged
        a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig[i] && irr[i] && !clr[i]) |=> irr[i]);
        // R6: a level-mode request tracks the pin
        a_r6_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
            trig[i] |=> (irr[i] == $past(pin[i])));
    end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
    parameter int NL = 8,
    parameter int LW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] irr,
    input  logic [NL-1:0] mask,
    input  logic          run,
    input  logic          inta,
    input  logic          aeoi,
    input  logic          eoi_spec,
    input  logic          eoi_any,
    input  logic [LW-1:0] eoi_lvl,
    input  logic          init_clr,
    input  logic [NL-LW-1:0] base_hi,
    output logic          intr,
    output logic [NL-1:0] isr,
    output logic [NL-1:0] vec_out,
    output logic          vec_vld,
    output logic [NL-1:0] ack_clr
);
    logic [NL-1:0] elig;
    logic [LW:0]   req_idx, isr_idx;
    logic          present, ack_take;
    logic [LW-1:0] lvl;
    logic [NL-1:0] isr_n;

    assign elig = irr & ~mask;

    always_comb begin
        req_idx = (LW+1)'(NL);
        isr_idx = (LW+1)'(NL);
        for (int i = NL-1; i >= 0; i--) begin
            if (elig[i]) req_idx = (LW+1)'(i);
            if (isr[i])  isr_idx = (LW+1)'(i);
        end
    end

    assign present  = run && (req_idx < isr_idx);
    assign intr     = present;
    assign ack_take = inta && present;
    assign lvl      = present ? req_idx[LW-1:0] : '1;

    for (genvar i = 0; i < NL; i++) begin : g_clr
        assign ack_clr[i] = ack_take && (lvl == LW'(i));
    end

    always_comb begin
        isr_n = isr;
        if (init_clr) begin
            isr_n = '0;
        end else begin
            if (eoi_spec) isr_n[eoi_lvl] = 1'b0;
            if (eoi_any && (isr_idx < (LW+1)'(NL))) isr_n[isr_idx[LW-1:0]] = 1'b0;
            if (ack_take && !aeoi) isr_n[lvl] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr     <= '0;
            vec_out <= '0;
            vec_vld <= 1'b0;
        end else begin
            isr     <= isr_n;
            vec_vld <= inta;
            if (inta) vec_out <= {base_hi, lvl};
        end
    end

    // R8: a normal acknowledge adds exactly one in-service level
    a_r8_isr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && intr && !aeoi && !eoi_spec && !eoi_any && !init_clr)
        |=> ($countones(isr) == $countones($past(isr)) + 1));
    // R9: specific end-of-interrupt clears its level
    a_r9_spec_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_spec && !inta) |=> !isr[$past(eoi_lvl)]);
    // R11: automatic mode leaves in-service untouched on acknowledge
    a_r11_auto_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && aeoi && !eoi_spec && !eoi_any && !init_clr) |=> (isr == $past(isr)));
    // R12: spurious acknowledge returns level 7 and keeps in-service
    a_r12_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !intr && !eoi_spec && !eoi_any && !init_clr)
        |=> (vec_out[LW-1:0] == '1 && isr == $past(isr)));
    // R8: vector valid follows acknowledge by one cycle
    a_r8_vec_valid: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> vec_vld);
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
#(
    parameter int NL = DATA_W,
    parameter int LW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          a0,
    input  logic          rd,
    input  logic          wr,
    input  logic          sel_trig,
    input  logic [NL-1:0] din,
    output logic [NL-1:0] dout,
    input  logic [NL-1:0] irq_in,
    input  logic          inta,
    output logic          intr,
    output logic [NL-1:0] vec_out,
    output logic          vec_vld,
    output logic [NL-1:0] casc_word
);
    logic          run, aeoi, rd_isr, eoi_spec, eoi_any, init_clr;
    logic [NL-1:0] vbase, mask, trig, irr, isr, ack_clr;
    logic [LW-1:0] eoi_lvl;

    pic8_cfg #(.NL(NL), .LW(LW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .wr(wr),
        .sel_trig(sel_trig), .din(din), .run(run), .vbase(vbase),
        .casc(casc_word), .aeoi(aeoi), .mask(mask), .trig(trig),
        .rd_isr(rd_isr), .eoi_spec(eoi_spec), .eoi_any(eoi_any),
        .eoi_lvl(eoi_lvl), .init_clr(init_clr)
    );

    pic8_req #(.NL(NL)) u_req (
        .clk(clk), .rst_n(rst_n), .pin(irq_in), .trig(trig),
        .clr(ack_clr), .irr(irr)
    );

    pic8_prio #(.NL(NL), .LW(LW)) u_prio (
        .clk(clk), .rst_n(rst_n), .irr(irr), .mask(mask), .run(run),
        .inta(inta), .aeoi(aeoi), .eoi_spec(eoi_spec), .eoi_any(eoi_any),
        .eoi_lvl(eoi_lvl), .init_clr(init_clr), .base_hi(vbase[NL-1:LW]),
        .intr(intr), .isr(isr), .vec_out(vec_out), .vec_vld(vec_vld),
        .ack_clr(ack_clr)
    );

    always_comb begin
        dout = '0;
        if (cs && rd) begin
            if (a0) dout = sel_trig ? trig : mask;
            else    dout = rd_isr ? isr : irr;
        end
    end

    // R7: no interrupt is raised before configuration completes
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !intr);
endmodule

// File: tb/test_pic8_ctrl.sv
module test_pic8_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 0, a0 = 0, rd = 0, wr = 0, sel_trig = 0, inta = 0;
    logic [7:0] din = 0, irq_in = 0;
    logic [7:0] dout, vec_out, casc_word;
    logic       intr, vec_vld;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    bit done = 0;

    pic8_ctrl i_pic8_ctrl (
        .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .rd(rd), .wr(wr),
        .sel_trig(sel_trig), .din(din), .dout(dout), .irq_in(irq_in),
        .inta(inta), .intr(intr), .vec_out(vec_out), .vec_vld(vec_vld),
        .casc_word(casc_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (vec_vld) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected vector", vec_out, 8'h00);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk("R8/R12 vector", vec_out, e);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wreg(input logic port, input logic trg, input logic [7:0] v);
        @(negedge clk);
        cs = 1; wr = 1; a0 = port; sel_trig = trg; din = v;
        @(negedge clk);
        cs = 0; wr = 0; sel_trig = 0;
    endtask

    task automatic rreg(input logic port, input logic trg, output logic [7:0] v);
        @(negedge clk);
        cs = 1; rd = 1; a0 = port; sel_trig = trg;
        #1 v = dout;
        cs = 0; rd = 0; sel_trig = 0;
    endtask

    task automatic ack(input logic [7:0] e);
        exp_q.push_back(e);
        @(negedge clk);
        inta = 1;
        @(negedge clk);
        inta = 0;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        irq_in[k] = 1;
        @(negedge clk);
        irq_in[k] = 0;
    endtask

    task automatic init4(input logic [7:0] base, input logic [7:0] cw, input logic [7:0] mode);
        wreg(0, 0, 8'h11);
        wreg(1, 0, base);
        wreg(1, 0, cw);
        wreg(1, 0, mode);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        rreg(1, 0, v); chk("R1 mask after reset", v, 8'hFF);
        rreg(0, 0, v); chk("R1 irr selected", v, 8'h00);
        chk("R1 intr low", {7'd0, intr}, 8'h00);

        init4(8'h20, 8'h04, 8'h01);
        chk("R13 cascade word", casc_word, 8'h04);
        wreg(1, 0, 8'h00);
        rreg(1, 0, v); chk("R3 mask readback", v, 8'h00);

        // edge request on line 3
        @(negedge clk); irq_in[3] = 1;
        step(); chk("R5 edge raises intr", {7'd0, intr}, 8'h01);
        rreg(0, 0, v); chk("R10 irr read", v, 8'h08);
        ack(8'h23);
        chk("R8 intr drops after ack", {7'd0, intr}, 8'h00);
        wreg(0, 0, 8'h0B);
        rreg(0, 0, v); chk("R10 isr read", v, 8'h08);
        wreg(0, 0, 8'h0A);
        rreg(0, 0, v); chk("R5 no re-request while pin held", v, 8'h00);

        // priority against in-service
        @(negedge clk); irq_in[5] = 1;
        step(); chk("R7 lower level blocked", {7'd0, intr}, 8'h00);
        @(negedge clk); irq_in[1] = 1;
        step(); chk("R7 higher level preempts", {7'd0, intr}, 8'h01);
        ack(8'h21);
        wreg(0, 0, 8'h0B);
        rreg(0, 0, v); chk("R8 two levels in service", v, 8'h0A);
        wreg(0, 0, 8'h63);
        rreg(0, 0, v); chk("R9 specific clears only 3", v, 8'h02);
        chk("R7 line 5 still below 1", {7'd0, intr}, 8'h00);
        wreg(0, 0, 8'h20);
        rreg(0, 0, v); chk("R9 nonspecific clears highest", v, 8'h00);
        chk("R7 line 5 now offered", {7'd0, intr}, 8'h01);
        ack(8'h25);
        wreg(0, 0, 8'h65);
        rreg(0, 0, v); chk("R10 selection persists", v, 8'h00);
        @(negedge clk); irq_in = 8'h00;

        // masking
        wreg(1, 0, 8'hFF);
        pulse(2);
        step(); chk("R3 masked line silent", {7'd0, intr}, 8'h00);
        wreg(0, 0, 8'h0A);
        rreg(0, 0, v); chk("R3 masked request recorded", v, 8'h04);
        wreg(1, 0, 8'hFB);
        chk("R3 unmask offers line", {7'd0, intr}, 8'h01);
        ack(8'h22);
        wreg(0, 0, 8'h62);

        // spurious acknowledge
        ack(8'h27);
        wreg(0, 0, 8'h0B);
        rreg(0, 0, v); chk("R12 isr unchanged", v, 8'h00);

        // level versus edge
        wreg(1, 1, 8'h40);
        rreg(1, 1, v); chk("R4 trigger readback", v, 8'h40);
        wreg(1, 0, 8'h00);
        wreg(0, 0, 8'h0A);
        @(negedge clk); irq_in[6] = 1;
        step(); rreg(0, 0, v); chk("R6 level high", v, 8'h40);
        @(negedge clk); irq_in[6] = 0;
        step(); rreg(0, 0, v); chk("R6 level follows low", v, 8'h00);
        pulse(4);
        step(); rreg(0, 0, v); chk("R5 edge latched", v, 8'h10);
        ack(8'h24);
        wreg(0, 0, 8'h64);
        @(negedge clk); irq_in[6] = 1;
        step(); ack(8'h26);
        rreg(0, 0, v); chk("R6 level re-asserts after ack", v, 8'h40);
        chk("R7 in-service blocks same level", {7'd0, intr}, 8'h00);
        @(negedge clk); irq_in[6] = 0;
        wreg(0, 0, 8'h66);

        // automatic end-of-interrupt
        init4(8'h40, 8'h04, 8'h03);
        pulse(0);
        step(); ack(8'h40);
        wreg(0, 0, 8'h0B);
        rreg(0, 0, v); chk("R11 auto eoi keeps isr clear", v, 8'h00);

        // shortened sequence: single, no mode word
        wreg(0, 0, 8'h12);
        wreg(1, 0, 8'h88);
        wreg(1, 0, 8'hFE);
        rreg(1, 0, v); chk("R2 write after short sequence is mask", v, 8'hFE);
        chk("R2 cascade word kept", casc_word, 8'h04);
        pulse(0);
        step(); ack(8'h88);
        wreg(0, 0, 8'h0B);
        rreg(0, 0, v); chk("R2 auto eoi cleared by restart", v, 8'h01);

        repeat (3) step();
        chk("R8 all vectors seen", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule